// File: doc/BRIEF.md
# Color Matrix Coefficient Encoder

This block turns one color-matrix coefficient into the 16-bit code that a pipe's color conversion registers take. Each coefficient comes in as a 64-bit sign-magnitude word. The top bit is the sign, and the lower 63 bits hold an unsigned magnitude with 32 fractional bits. The block limits the magnitude to just under four. It then sorts the magnitude into one of six bands. Each band has its own 3-bit exponent code and its own window of nine mantissa bits. The mantissa is rounded and saturated inside that window. The result is a small floating-point-like code whose exponent values do not rise in numeric order.

Coefficients enter and codes leave over valid/ready handshakes, one code per coefficient, through a two-stage pipeline. The first stage clamps the magnitude and picks the band. The second stage shifts, rounds and packs. A full color matrix is a run of nine coefficients. A start pulse restarts the position count, and every code leaves with its position in the run and a flag on the last one.

Top module: `coef_code_encoder`

## Requirements
- R1: Output bit 15 equals input bit 63 for every coefficient, including a zero magnitude.
- R2: Any magnitude of 4.0 (0x4_0000_0000) or above is treated as 0x3_FFFF_FFFF, so every such input yields exponent 6 with mantissa field 0xFF8.
- R3: Output bits 14:12 hold the exponent code of the magnitude's band: 3 below 0.125, 2 from 0.125 up to 0.25, 1 from 0.25 up to 0.5, 0 from 0.5 up to 1.0, 7 from 1.0 up to 2.0, and 6 from 2.0 upward. Codes 4 and 5 never appear.
- R4: Output bits 11:0 are computed as follows. Take the band's fractional-bit count f, which is 12, 11, 10, 9, 8 and 7 from the lowest band to the highest. Shift the clamped magnitude right by 29−f. Add 4. Saturate the sum at 0xFFF. Clear bits 2:0. A value just under a band edge therefore saturates to 0xFF8 instead of carrying into the next band.
- R5: Output bits 2:0 are always zero.
- R6: An input of exactly 1.0 (0x1_0000_0000) encodes as 0x7800.
- R7: A zero magnitude encodes as 0x3000, or as 0xB000 when the sign bit is set.
- R8: There are two register stages. When the pipeline is empty, a coefficient accepted at edge k sets out_valid after edge k+1. in_ready is high whenever out_valid is low.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_code, out_idx and out_last hold steady. Every accepted coefficient produces exactly one code, and codes leave in the order the coefficients were accepted.
- R10: Each accepted coefficient is given a position in the run.
  - With seq_start high during the accept, the position is 0.
  - Otherwise the position is one more than the previous one, wrapping from 8 back to 0.
  - seq_start high with no accept makes the next coefficient position 0.
  - out_idx carries the position, and out_last is high exactly when it is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Coefficient present |
| in_ready | output | 1 | Encoder can take a coefficient |
| in_coef | input | 64 | Sign-magnitude coefficient, 32 fractional bits |
| seq_start | input | 1 | Restart the nine-coefficient position count |
| out_valid | output | 1 | Code present |
| out_ready | input | 1 | Consumer takes the code |
| out_code | output | 16 | Sign, exponent code, mantissa field |
| out_idx | output | 4 | Position of the code within the run |
| out_last | output | 1 | Code is the final one of the run |

## Verification
The hardest case to reach is mantissa saturation just below each band edge. It only occurs for magnitudes within a few units of the window's least significant bit under a power of two. The stimulus therefore walks each edge directly, using the value one below it and the value at it. Random magnitudes spread over about forty shift amounts then fill in the bands. The bench also applies random backpressure while seq_start pulses arrive both with an accept and on their own. This keeps both pipeline stages full while the position count restarts.

// File: rtl/coefenc_pkg.sv
package coefenc_pkg;

   localparam int NUM_BANDS = 6;
   localparam int BAND_W    = 3;
   localparam int EXP_W     = 3;

   typedef logic [BAND_W-1:0] band_t;

   // Band 0 is the smallest magnitude range; exponent codes are not monotonic.
   function automatic logic [EXP_W-1:0] band_to_exp(input band_t b);
      logic [EXP_W-1:0] e;
      case (b)
         3'd0:    e = 3'd3;
         3'd1:    e = 3'd2;
         3'd2:    e = 3'd1;
         3'd3:    e = 3'd0;
         3'd4:    e = 3'd7;
         default: e = 3'd6;
      endcase
      return e;
   endfunction

endpackage

// File: rtl/coefenc_band_sel.sv
module coefenc_band_sel
   import coefenc_pkg::*;
#(
   parameter int RAW_W  = 63,
   parameter int MAG_W  = 34,
   parameter int FRAC_W = 32
) (
   input  logic [RAW_W-1:0] raw_mag,
   output logic [MAG_W-1:0] clip_mag,
   output band_t            band
);

   localparam logic [MAG_W-1:0] CLIP_MAX = {MAG_W{1'b1}};
   localparam int NUM_EDGES = NUM_BANDS - 1;
   localparam int EDGE_LO   = FRAC_W - 3;

   logic over;
   logic [NUM_EDGES-1:0] below;

   assign over     = |raw_mag[RAW_W-1:MAG_W];
   assign clip_mag = over ? CLIP_MAX : raw_mag[MAG_W-1:0];

   // Thermometer of "below edge k"; edges are 2^(FRAC_W-3+k).
   for (genvar k = 0; k < NUM_EDGES; k++) begin : g_edge
      localparam logic [MAG_W-1:0] EDGE = MAG_W'(1) << (EDGE_LO + k);
      assign below[k] = clip_mag < EDGE;
   end

   assign band = BAND_W'(NUM_EDGES) - BAND_W'($countones(below));

endmodule

// File: rtl/coefenc_pack.sv
module coefenc_pack
   import coefenc_pkg::*;
#(
   parameter int MAG_W   = 34,
   parameter int FRAC_W  = 32,
   parameter int MANT_W  = 9,
   parameter int GUARD_W = 3,
   localparam int WIN_W  = MANT_W + GUARD_W,
   localparam int OUT_W  = 1 + EXP_W + WIN_W
) (
   input  logic             sign,
   input  band_t            band,
   input  logic [MAG_W-1:0] clip_mag,
   output logic [OUT_W-1:0] code
);

   localparam int SHIFT_BASE = FRAC_W - 3 - WIN_W;
   localparam logic [MAG_W:0]   ROUND_ADD = (MAG_W+1)'(1) << (GUARD_W - 1);
   localparam logic [MAG_W:0]   WIN_MAX   = (MAG_W+1)'({WIN_W{1'b1}});
   localparam logic [WIN_W-1:0] KEEP_MASK = {{MANT_W{1'b1}}, {GUARD_W{1'b0}}};

   logic [WIN_W-1:0] cand [8];

   for (genvar b = 0; b < 8; b++) begin : g_win
      if (b < NUM_BANDS) begin : g_real
         logic [MAG_W:0]   rounded;
         logic [WIN_W-1:0] sat;
         assign rounded = {1'b0, clip_mag >> (SHIFT_BASE + b)} + ROUND_ADD;
         assign sat     = (rounded > WIN_MAX) ? WIN_MAX[WIN_W-1:0] : rounded[WIN_W-1:0];
         assign cand[b] = sat & KEEP_MASK;
      end else begin : g_pad
         assign cand[b] = '0;
      end
   end

   assign code = {sign, band_to_exp(band), cand[band]};

endmodule

// File: rtl/coef_code_encoder.sv
module coef_code_encoder
   import coefenc_pkg::*;
#(
   parameter int IN_W      = 64,
   parameter int FRAC_W    = 32,
   parameter int INT_W     = 2,
   parameter int MANT_W    = 9,
   parameter int SEQ_LEN   = 9,
   localparam int GUARD_W  = 3,
   localparam int OUT_W    = 1 + EXP_W + MANT_W + GUARD_W,
   localparam int IDX_W    = $clog2(SEQ_LEN) < 1 ? 1 : $clog2(SEQ_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [IN_W-1:0]  in_coef,
   input  logic             seq_start,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OUT_W-1:0] out_code,
   output logic [IDX_W-1:0] out_idx,
   output logic             out_last
);

   localparam int RAW_W = IN_W - 1;
   localparam int MAG_W = FRAC_W + INT_W;
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(SEQ_LEN - 1);

   initial begin
      assert (MAG_W < RAW_W) else $error("magnitude width exceeds input");
      assert (FRAC_W >= MANT_W + GUARD_W + 3) else $error("fraction too narrow");
      assert (INT_W == 2) else $error("band layout assumes clamp below 4.0");
      assert (SEQ_LEN >= 2) else $error("run length too short");
   end

   // ---------------- stage 1: clamp and band select ----------------
   logic [MAG_W-1:0] clip_mag_c;
   band_t            band_c;

   coefenc_band_sel #(.RAW_W(RAW_W), .MAG_W(MAG_W), .FRAC_W(FRAC_W)) u_band (
      .raw_mag  (in_coef[RAW_W-1:0]),
      .clip_mag (clip_mag_c),
      .band     (band_c)
   );

   logic             s1_valid;
   logic             s1_sign;
   band_t            s1_band;
   logic [MAG_W-1:0] s1_mag;
   logic [IDX_W-1:0] s1_idx;

   logic out_take, accept;
   logic [IDX_W-1:0] seq_cnt, cur_idx;

   assign out_take = !out_valid || out_ready;
   assign in_ready = !s1_valid || out_take;
   assign accept   = in_valid && in_ready;
   assign cur_idx  = seq_start ? '0 : seq_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_cnt <= '0;
      end else if (accept) begin
         seq_cnt <= (cur_idx == IDX_END) ? '0 : cur_idx + IDX_W'(1);
      end else if (seq_start) begin
         seq_cnt <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sign  <= 1'b0;
         s1_band  <= '0;
         s1_mag   <= '0;
         s1_idx   <= '0;
      end else if (accept) begin
         s1_valid <= 1'b1;
         s1_sign  <= in_coef[IN_W-1];
         s1_band  <= band_c;
         s1_mag   <= clip_mag_c;
         s1_idx   <= cur_idx;
      end else if (out_take) begin
         s1_valid <= 1'b0;
      end
   end

   // ---------------- stage 2: window, round, pack ----------------
   logic [OUT_W-1:0] code_c;

   coefenc_pack #(.MAG_W(MAG_W), .FRAC_W(FRAC_W), .MANT_W(MANT_W), .GUARD_W(GUARD_W)) u_pack (
      .sign     (s1_sign),
      .band     (s1_band),
      .clip_mag (s1_mag),
      .code     (code_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
         out_idx   <= '0;
         out_last  <= 1'b0;
      end else if (out_take) begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            out_code <= code_c;
            out_idx  <= s1_idx;
            out_last <= (s1_idx == IDX_END);
         end
      end
   end

   // ---------------- assertions ----------------
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_idx) && $stable(out_last)); // R9

   AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready); // R8

   AST_EXP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_code[OUT_W-2 -: EXP_W] != 3'd4) && (out_code[OUT_W-2 -: EXP_W] != 3'd5)); // R3

   AST_GUARD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_code[GUARD_W-1:0] == '0); // R5

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_idx <= IDX_END); // R10

   AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid && !out_valid && accept |=> !out_valid); // R8

endmodule

// File: tb/coef_code_encoder_tb.sv
module coef_code_encoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_coef = '0;
   logic        seq_start = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_code;
   logic [3:0]  out_idx;
   logic        out_last;

   always #2 clk = ~clk;   // 250 MHz

   coef_code_encoder u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_coef(in_coef), .seq_start(seq_start), .out_valid(out_valid),
      .out_ready(out_ready), .out_code(out_code), .out_idx(out_idx), .out_last(out_last)
   );

   typedef struct {
      logic [15:0] code;
      logic [3:0]  idx;
      logic        last;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   failures = 0;
   int   tb_cnt = 0;
   bit   bp_on = 1'b0;
   bit   done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endtask

   // Reference encoding written from the requirement text
   function automatic logic [15:0] model(input logic [63:0] c);
      logic [63:0] m;
      logic [63:0] w;
      int f;
      logic [2:0] e;
      m = {1'b0, c[62:0]};
      if (m >= 64'h4_0000_0000) m = 64'h3_FFFF_FFFF;          // R2
      if      (m < 64'h0_2000_0000) begin e = 3'd3; f = 12; end  // R3
      else if (m < 64'h0_4000_0000) begin e = 3'd2; f = 11; end
      else if (m < 64'h0_8000_0000) begin e = 3'd1; f = 10; end
      else if (m < 64'h1_0000_0000) begin e = 3'd0; f = 9;  end
      else if (m < 64'h2_0000_0000) begin e = 3'd7; f = 8;  end
      else                          begin e = 3'd6; f = 7;  end
      w = (m >> (29 - f)) + 64'd4;                               // R4
      if (w > 64'hFFF) w = 64'hFFF;
      w = w & 64'hFF8;
      return {c[63], e, w[11:0]};
   endfunction

   task automatic send(input logic [63:0] c, input bit st, input string tag);
      exp_t it;
      int idx;
      @(negedge clk);
      in_valid  = 1'b1;
      in_coef   = c;
      seq_start = st;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      idx     = st ? 0 : tb_cnt;
      tb_cnt  = (idx == 8) ? 0 : idx + 1;
      it.code = model(c);
      it.idx  = 4'(idx);
      it.last = (idx == 8);
      it.tag  = tag;
      q.push_back(it);
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid  = 1'b0;
      seq_start = 1'b0;
   endtask

   task automatic start_only();   // R10 start without accept
      @(negedge clk);
      in_valid  = 1'b0;
      seq_start = 1'b1;
      tb_cnt    = 0;
      @(negedge clk);
      seq_start = 1'b0;
   endtask

   // Backpressure driver
   always @(negedge clk) begin
      out_ready <= bp_on ? (($urandom % 3) != 0) : 1'b1;
   end

   // Monitor / scoreboard
   initial begin
      logic        was_stall;
      logic [15:0] held_code;
      logic [3:0]  held_idx;
      exp_t it;
      was_stall = 1'b0;
      held_code = '0;
      held_idx  = '0;
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (was_stall) begin
               chk(out_valid && out_code == held_code && out_idx == held_idx,
                   "R9 hold under stall", {out_valid, out_code}, {1'b1, held_code});
            end
            was_stall = out_valid && !out_ready;
            held_code = out_code;
            held_idx  = out_idx;
            if (out_valid && out_ready) begin
               if (q.size() == 0) begin
                  chk(1'b0, "R9 unexpected code", 64'(out_code), 64'(0));
               end else begin
                  it = q.pop_front();
                  chk(out_code[15] == it.code[15], "R1 sign", 64'(out_code[15]), 64'(it.code[15]));
                  chk(out_code[14:12] == it.code[14:12], "R3 exponent", 64'(out_code[14:12]), 64'(it.code[14:12]));
                  chk(out_code[2:0] == 3'd0, "R5 guard bits", 64'(out_code[2:0]), 64'(0));
                  chk(out_code == it.code, it.tag, 64'(out_code), 64'(it.code));
                  chk(out_idx == it.idx && out_last == it.last, "R10 position",
                      {out_idx, out_last}, {it.idx, it.last});
               end
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(!out_valid && in_ready, "R8 reset state", {out_valid, in_ready}, 2'b01);
      @(negedge clk);
      rst_n = 1'b1;

      // R8 fill latency on an empty pipeline
      send(64'h1_0000_0000, 1'b1, "R6 unity");
      idle();
      #1;
      chk(!out_valid, "R8 one stage after accept", 64'(out_valid), 64'(0));
      @(negedge clk);
      #1;
      chk(out_valid, "R8 two stages after accept", 64'(out_valid), 64'(1));
      chk(out_code == 16'h7800, "R6 unity code", 64'(out_code), 64'h7800);
      repeat (2) @(negedge clk);

      // R7 zero, both signs; R1 sign
      send(64'h0, 1'b0, "R7 zero");
      send(64'h8000_0000_0000_0000, 1'b0, "R7 negative zero");
      send(64'h8000_0001_0000_0000, 1'b0, "R1 negative unity");
      // R3/R4 band edges
      for (int k = 29; k <= 33; k++) begin
         send((64'd1 << k) - 64'd1, 1'b0, "R4 just below edge");
         send(64'd1 << k, 1'b0, "R3 at edge");
      end
      send(64'h0_0001_2345, 1'b0, "R4 small band");
      send(64'h0_C000_0000, 1'b0, "R4 three quarters");
      // R2 clamp
      send(64'h3_FFFF_FFFF, 1'b0, "R2 largest in range");
      send(64'h4_0000_0000, 1'b0, "R2 at four");
      send(64'h7FFF_FFFF_FFFF_FFFF, 1'b0, "R2 huge");
      send(64'hC000_0000_0000_0000, 1'b0, "R2 huge negative");
      idle();
      repeat (4) @(negedge clk);

      // R10 start without accept, then run wrap
      send(64'h0_4000_0000, 1'b0, "R4 pre-start");
      send(64'h0_2000_0000, 1'b0, "R4 pre-start");
      start_only();
      for (int i = 0; i < 20; i++) send(64'(i) << 27, 1'b0, "R10 run item");
      idle();

      // Random with backpressure (R9) and random starts (R10)
      bp_on = 1'b1;
      for (int i = 0; i < 400; i++) begin
         logic [63:0] c;
         int sh;
         sh = $urandom % 40;
         c  = {$urandom, $urandom} >> sh;
         c[63] = $urandom % 2;
         if (($urandom % 25) == 0) start_only();
         send(c, ($urandom % 17) == 0, "R4 random");
         if (($urandom % 7) == 0) idle();
      end
      idle();
      bp_on = 1'b0;

      repeat (20) @(negedge clk);
      chk(q.size() == 0, "R9 all codes delivered", 64'(q.size()), 64'(0));
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule